// File: doc/BRIEF.md
# Dual-Chain Carry-Select Arithmetic Row

This block is a row of one-bit arithmetic cells that forms a registered adder, subtractor or up/down counter of parameterised width (10 bits by default). Every cell works out its carry-out twice. One value assumes the group carry-in is 0 and the other assumes it is 1. Two carry chains therefore run side by side along the row, and the group carry-in only picks one of them at the end. A single group-wide subtract select inverts the second operand in every cell. The same select also enters the chain as the carry of the first cell, which completes the two's complement.

The combined result is available both unregistered and in a result register. The register has a clock enable, a synchronous clear and a synchronous load. With the counter enable high, the row feeds its own register back as the first operand and adds +1 or −1 under up/down control. In that mode the operand ports, the subtract select and the group carry-in are ignored.

Top module: `csa_arith_row`

## Requirements
- R1: With cnt_en=0 and sub_sel=0, sum_comb equals (a_in + b_in + grp_cin) mod 2^WIDTH, and carry_out is bit WIDTH of that sum.
- R2: With cnt_en=0 and sub_sel=1, sum_comb equals (a_in − b_in − grp_cin) mod 2^WIDTH. carry_out is 1 exactly when a_in ≥ b_in + grp_cin, that is, when no borrow occurs.
- R3: On a rising clk edge with clk_en=1, sync_clr=0, sync_ld=0 and cnt_en=0, sum_q takes the value sum_comb had before the edge.
- R4: While clk_en=0, sum_q keeps its value whatever sync_clr, sync_ld, cnt_en or the operands do.
- R5: On a rising edge with clk_en=1 and sync_clr=1, sum_q becomes 0. Clear wins over load and over counting.
- R6: On a rising edge with clk_en=1, sync_clr=0 and sync_ld=1, sum_q becomes ld_data. Load wins over counting and over the arithmetic result.
- R7: With clk_en=1, cnt_en=1 and cnt_up=1, sum_q increases by 1 on each edge and wraps from all ones to 0. a_in, b_in, sub_sel and grp_cin have no effect.
- R8: With clk_en=1, cnt_en=1 and cnt_up=0, sum_q decreases by 1 on each edge and wraps from 0 to all ones.
- R9: With cnt_en=1, sum_comb shows the next count. carry_out is 1 when counting up from all ones, and 1 when counting down from any value other than 0.
- R10: While rst_n is low, sum_q is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the result register |
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| sub_sel | input | 1 | 1 selects subtraction, 0 addition |
| grp_cin | input | 1 | Group carry-in; picks the speculative chain (acts as borrow when subtracting) |
| clk_en | input | 1 | Register update enable |
| cnt_en | input | 1 | Counter mode: register fed back, ±1 applied |
| cnt_up | input | 1 | 1 counts up, 0 counts down |
| sync_clr | input | 1 | Synchronous clear of the register |
| sync_ld | input | 1 | Synchronous load of ld_data |
| ld_data | input | WIDTH | Value taken on synchronous load |
| sum_q | output | WIDTH | Registered result |
| sum_comb | output | WIDTH | Unregistered result |
| carry_out | output | 1 | Carry-out of the selected chain |

## Verification
The bench builds the row at its default WIDTH of 10. At that width the all-ones and zero operands are easy to drive directly, and the counter reaches both wrap points within a few cycles of a load. Random operands in add and subtract mode exercise both chains, and grp_cin is randomised so that each chain's sum and carry are picked. A behavioural model in plain integers predicts sum_q, sum_comb and carry_out every cycle.

// File: rtl/csa_pkg.sv
package csa_pkg;
  // Carry-out of one cell for a given incoming carry
  function automatic logic cell_cout(input logic a, input logic b, input logic cin);
    return cin ? (a | b) : (a & b);
  endfunction

  function automatic logic cell_sum(input logic a, input logic b, input logic cin);
    return a ^ b ^ cin;
  endfunction

  // Counter step operand: +1 or all ones (-1)
  function automatic logic [63:0] step_operand(input logic up);
    return up ? 64'd1 : {64{1'b1}};
  endfunction
endpackage

// File: rtl/csa_cell.sv
module csa_cell
  import csa_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic sub,
  input  logic c0_in,
  input  logic c1_in,
  output logic s0,
  output logic s1,
  output logic c0_out,
  output logic c1_out
);
  logic b_eff;
  assign b_eff  = b ^ sub;
  assign s0     = cell_sum(a, b_eff, c0_in);
  assign s1     = cell_sum(a, b_eff, c1_in);
  assign c0_out = cell_cout(a, b_eff, c0_in);
  assign c1_out = cell_cout(a, b_eff, c1_in);
endmodule

// File: rtl/csa_chain.sv
module csa_chain #(
  parameter int WIDTH = 10
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  logic [WIDTH:0]   c0;
  logic [WIDTH:0]   c1;
  logic [WIDTH-1:0] s0;
  logic [WIDTH-1:0] s1;

  // subtract select enters as first-cell carry; chain 1 assumes the opposite
  assign c0[0] = sub;
  assign c1[0] = ~sub;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    csa_cell u_cell (
      .a      (op_a[i]),
      .b      (op_b[i]),
      .sub    (sub),
      .c0_in  (c0[i]),
      .c1_in  (c1[i]),
      .s0     (s0[i]),
      .s1     (s1[i]),
      .c0_out (c0[i+1]),
      .c1_out (c1[i+1])
    );
  end

  assign sum  = cin ? s1 : s0;
  assign cout = cin ? c1[WIDTH] : c0[WIDTH];
endmodule

// File: rtl/csa_opsel.sv
module csa_opsel
  import csa_pkg::*;
#(
  parameter int WIDTH = 10
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [WIDTH-1:0] fb_q,
  input  logic             sub_sel,
  input  logic             grp_cin,
  input  logic             cnt_en,
  input  logic             cnt_up,
  output logic [WIDTH-1:0] op_a,
  output logic [WIDTH-1:0] op_b,
  output logic             sub_eff,
  output logic             cin_eff
);
  logic [63:0] step;
  assign step    = step_operand(cnt_up);
  assign op_a    = cnt_en ? fb_q : a_in;
  assign op_b    = cnt_en ? step[WIDTH-1:0] : b_in;
  assign sub_eff = cnt_en ? 1'b0 : sub_sel;
  assign cin_eff = cnt_en ? 1'b0 : grp_cin;
endmodule

// File: rtl/csa_arith_row.sv
module csa_arith_row #(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             sub_sel,
  input  logic             grp_cin,
  input  logic             clk_en,
  input  logic             cnt_en,
  input  logic             cnt_up,
  input  logic             sync_clr,
  input  logic             sync_ld,
  input  logic [WIDTH-1:0] ld_data,
  output logic [WIDTH-1:0] sum_q,
  output logic [WIDTH-1:0] sum_comb,
  output logic             carry_out
);
  localparam int W1 = WIDTH + 1;

  logic [WIDTH-1:0] op_a;
  logic [WIDTH-1:0] op_b;
  logic             sub_eff;
  logic             cin_eff;

  // named update events
  logic upd_clr;
  logic upd_load;
  logic upd_arith;

  csa_opsel #(.WIDTH(WIDTH)) u_opsel (
    .a_in    (a_in),
    .b_in    (b_in),
    .fb_q    (sum_q),
    .sub_sel (sub_sel),
    .grp_cin (grp_cin),
    .cnt_en  (cnt_en),
    .cnt_up  (cnt_up),
    .op_a    (op_a),
    .op_b    (op_b),
    .sub_eff (sub_eff),
    .cin_eff (cin_eff)
  );

  csa_chain #(.WIDTH(WIDTH)) u_chain (
    .op_a (op_a),
    .op_b (op_b),
    .sub  (sub_eff),
    .cin  (cin_eff),
    .sum  (sum_comb),
    .cout (carry_out)
  );

  assign upd_clr   = clk_en & sync_clr;
  assign upd_load  = clk_en & ~sync_clr & sync_ld;
  assign upd_arith = clk_en & ~sync_clr & ~sync_ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sum_q <= '0;
    else if (upd_clr)   sum_q <= '0;
    else if (upd_load)  sum_q <= ld_data;
    else if (upd_arith) sum_q <= sum_comb;
  end

  // ---------------- assertions ----------------
  p_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !sub_sel) |->
      ({carry_out, sum_comb} == (W1'(a_in) + W1'(b_in) + W1'(grp_cin))));

  p_sub_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && sub_sel) |->
      (carry_out == (W1'(a_in) >= (W1'(b_in) + W1'(grp_cin)))));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(sum_q));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && sync_clr) |=> (sum_q == '0));

  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sync_clr && sync_ld) |=> (sum_q == $past(ld_data)));

  p_count_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sync_clr && !sync_ld && cnt_en && cnt_up) |=>
      (sum_q == WIDTH'($past(sum_q) + 1'b1)));

  p_count_dn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sync_clr && !sync_ld && cnt_en && !cnt_up) |=>
      (sum_q == WIDTH'($past(sum_q) - 1'b1)));

  p_onehot_upd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({upd_clr, upd_load, upd_arith}));
endmodule

// File: tb/csa_arith_row_tb_top.sv
module csa_arith_row_tb_top;
  localparam int W = 10;
  localparam longint MOD = 64'd1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0, ld_data = '0;
  logic sub_sel = 0, grp_cin = 0, clk_en = 0, cnt_en = 0, cnt_up = 0;
  logic sync_clr = 0, sync_ld = 0;
  logic [W-1:0] sum_q, sum_comb;
  logic carry_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  longint mq = 0;

  always #4 clk = ~clk;

  csa_arith_row #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .sub_sel(sub_sel),
    .grp_cin(grp_cin), .clk_en(clk_en), .cnt_en(cnt_en), .cnt_up(cnt_up),
    .sync_clr(sync_clr), .sync_ld(sync_ld), .ld_data(ld_data),
    .sum_q(sum_q), .sum_comb(sum_comb), .carry_out(carry_out)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // expected combinational result from the requirements
  task automatic expect_comb(output longint es, output longint ec);
    longint t;
    if (cnt_en) begin
      if (cnt_up) begin t = mq + 1; es = t % MOD; ec = (mq == MOD - 1); end
      else begin es = (mq == 0) ? MOD - 1 : mq - 1; ec = (mq != 0); end
    end else if (!sub_sel) begin
      t = longint'(a_in) + longint'(b_in) + longint'(grp_cin);
      es = t % MOD; ec = (t >= MOD);
    end else begin
      t = longint'(a_in) - longint'(b_in) - longint'(grp_cin);
      es = (t + MOD) % MOD; ec = (t >= 0);
    end
  endtask

  // inputs already driven after a negedge: check, then take the edge
  task automatic step(input string tag);
    longint es, ec;
    #1;
    expect_comb(es, ec);
    chk(tag, "sum_q", sum_q, mq);
    chk(tag, "sum_comb", sum_comb, es);
    chk(tag, "carry_out", carry_out, ec);
    @(posedge clk);
    if (clk_en) begin
      if (sync_clr) mq = 0;
      else if (sync_ld) mq = ld_data;
      else mq = es;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    clk_en = 0; cnt_en = 0; sync_clr = 0; sync_ld = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    #1 chk("R10", "sum_q in reset", sum_q, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 add, directed wrap and random
    clk_en = 1;
    a_in = '1; b_in = 10'd1; grp_cin = 0; step("R1");
    a_in = '1; b_in = '1; grp_cin = 1; step("R1");
    a_in = 10'd5; b_in = 10'd7; grp_cin = 1; step("R3");
    for (int i = 0; i < 300; i++) begin
      a_in = W'($urandom); b_in = W'($urandom); grp_cin = 1'($urandom);
      sub_sel = 0; step("R1");
    end
    // R2 subtract, directed and random
    sub_sel = 1;
    a_in = 10'd0; b_in = 10'd1; grp_cin = 0; step("R2");
    a_in = 10'd9; b_in = 10'd9; grp_cin = 0; step("R2");
    a_in = 10'd9; b_in = 10'd9; grp_cin = 1; step("R2");
    a_in = 10'd0; b_in = 10'd0; grp_cin = 1; step("R2");
    for (int i = 0; i < 300; i++) begin
      a_in = W'($urandom); b_in = W'($urandom); grp_cin = 1'($urandom);
      step("R2");
    end
    // R4 hold with everything else toggling
    clk_en = 0;
    for (int i = 0; i < 20; i++) begin
      sync_clr = 1'($urandom); sync_ld = 1'($urandom); cnt_en = 1'($urandom);
      cnt_up = 1'($urandom); ld_data = W'($urandom); a_in = W'($urandom);
      step("R4");
    end
    idle();
    // R6 load, priority over counting
    clk_en = 1; sync_ld = 1; cnt_en = 1; cnt_up = 1; ld_data = 10'd1020; step("R6");
    sync_ld = 0;
    // R7 count up through wrap, operand ports scrambled
    for (int i = 0; i < 8; i++) begin
      a_in = W'($urandom); b_in = W'($urandom); sub_sel = 1'($urandom); grp_cin = 1'($urandom);
      step("R7");
    end
    // R5 clear beats load and count
    sync_clr = 1; sync_ld = 1; ld_data = 10'd77; step("R5");
    sync_clr = 0; sync_ld = 0;
    // R8 count down through wrap from 0
    cnt_up = 0;
    for (int i = 0; i < 6; i++) step("R8");
    // R9 count outputs while frozen
    clk_en = 0; cnt_up = 1; step("R9"); cnt_up = 0; step("R9");
    // mixed random run
    for (int i = 0; i < 400; i++) begin
      clk_en = ($urandom % 4) != 0; cnt_en = ($urandom % 3) == 0; cnt_up = 1'($urandom);
      sync_clr = ($urandom % 16) == 0; sync_ld = ($urandom % 8) == 0;
      ld_data = W'($urandom); a_in = W'($urandom); b_in = W'($urandom);
      sub_sel = 1'($urandom); grp_cin = 1'($urandom);
      step("R3");
    end
    idle();
    rst_n = 0; #1 chk("R10", "sum_q after reset", sum_q, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule